// File: doc/BRIEF.md
# Configuration Override Word Scanner

At startup this block reads through one section of retained memory and decodes each 32-bit word in it. A word may ask for a new weight or a new persistence value for one numbered error flag. For each such word the block gives one single-cycle write strobe on a weight-update port or on a persistence-update port. Each port carries the flag number and the new value. The tables that hold these values sit elsewhere and take these strobes directly.

The block decides what each word means from its lowest byte. Words it does not recognise are passed over without any error. A section filled with zeroes therefore changes nothing, and software may leave unused room in the section without harm. A pulse on the start input sets the section's first word address and its length in words. The block reads the words from lowest to highest address over a read port whose data arrives one cycle after the request. When all updates are out, it gives a single-cycle completion pulse.

Top module: `cfg_override_scanner`

## Requirements
- R1: A word whose bits [7:0] equal 0xA2 is a weight entry. It produces one pulse on `wt_we_o`, with `wt_flag_o` = bits [23:16] and `wt_val_o` = bits [15:8].
- R2: A word whose bits [7:0] equal 0x8E is a persistence entry. It produces one pulse on `ps_we_o`, with `ps_flag_o` = bits [23:16] and `ps_val_o` = bits [15:8].
- R3: Bits [31:24] of a word have no effect on how it is decoded or on the value that goes out.
- R4: Any other word produces no strobe and no error. A zero-filled section produces no strobes at all.
- R5: A weight or persistence word whose flag number is NUM_FLAGS (default 48) or more is treated as unrecognised and produces no strobe.
- R6: After a start, the block requests addresses `base_i`, `base_i`+1, … up to `base_i`+`len_i`-1, each exactly once. Strobes come out in that address order, so when two entries name the same flag, the later one is applied last.
- R7: Each recognised word gives exactly one strobe, one cycle wide. The two update ports never pulse in the same cycle.
- R8: `done_o` pulses for one cycle after the last update of a scan, and no strobe is high in that cycle. With `len_i` = 0 there are no reads, and `done_o` still pulses once.
- R9: A start pulse that arrives while a scan is running is ignored. It causes no extra reads, no extra updates and no extra completion pulse.
- R10: During and straight after reset, `rd_en_o`, `wt_we_o`, `ps_we_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| start_i | input | 1 | Starts a scan when idle |
| base_i | input | ADDR_W | Word address of the first word in the section |
| len_i | input | ADDR_W+1 | Length of the section in words |
| rd_en_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read word address |
| rd_data_i | input | 32 | Read data, valid one cycle after the request |
| wt_we_o | output | 1 | Weight update strobe |
| wt_flag_o | output | 8 | Flag number for the weight update |
| wt_val_o | output | 8 | New weight |
| ps_we_o | output | 1 | Persistence update strobe |
| ps_flag_o | output | 8 | Flag number for the persistence update |
| ps_val_o | output | 8 | New persistence value |
| done_o | output | 1 | Scan-complete pulse |

## Verification
The assertions are checked on every cycle. They cover the following:
- the two update ports never pulse together, and every strobe carries a flag number below the limit;
- each strobe follows a read that returned data;
- the read address moves up by one on each cycle of a running scan;
- the completion pulse falls in a cycle with no update;
- a start pulse during a scan leaves the word count running down as before.

Only the bench scenarios can show the rest, by comparing the update stream with a queue built from the memory image:
- that each opcode and field is decoded correctly, and that the top byte is ignored;
- that unknown, zero and out-of-range words produce nothing;
- that a repeated flag comes out in address order;
- that an empty section still completes.

// File: rtl/cos_pkg.sv
package cos_pkg;

  localparam int          WORD_W     = 32;
  localparam logic [7:0]  OP_WEIGHT  = 8'hA2;
  localparam logic [7:0]  OP_PERSIST = 8'h8E;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic       wt;
    logic       ps;
    logic [7:0] flag;
    logic [7:0] val;
  } upd_s;

endpackage

// File: rtl/cos_addr_seq.sv
module cos_addr_seq
  import cos_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W:0]   len_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              last_o,
  output logic              empty_o
);

  localparam int LEN_W = ADDR_W + 1;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              empty_q, empty_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    left_d  = left_q;
    empty_d = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          if (len_i == '0) begin
            empty_d = 1'b1;
          end else begin
            state_d = SEQ_RUN;
            addr_d  = base_i;
            left_d  = len_i;
          end
        end
      end
      SEQ_RUN: begin
        addr_d = addr_q + 1'b1;
        left_d = left_q - 1'b1;
        if (left_q == LEN_W'(1)) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      empty_q <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      empty_q <= empty_d;
    end
  end

  assign rd_en_o   = (state_q == SEQ_RUN);
  assign rd_addr_o = addr_q;
  assign last_o    = rd_en_o && (left_q == LEN_W'(1));
  assign empty_o   = empty_q;

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == $past(rd_addr_o) + 1'b1));

  assert_count_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUN) |-> (left_q != '0));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUN && left_q != LEN_W'(1))
      |=> (state_q == SEQ_RUN && left_q == $past(left_q) - 1'b1));

endmodule

// File: rtl/cos_word_decode.sv
module cos_word_decode
  import cos_pkg::*;
#(
  parameter int NUM_FLAGS = 48
) (
  input  logic              vld_i,
  input  logic [WORD_W-1:0] word_i,
  output upd_s              upd_o
);

  logic [7:0] op_b;
  logic [7:0] val_b;
  logic [7:0] flag_b;
  logic       in_range;

  assign op_b   = word_i[7:0];
  assign val_b  = word_i[15:8];
  assign flag_b = word_i[23:16];
  // word_i[31:24] is reserved and never looked at

  generate
    if (NUM_FLAGS >= 256) begin : g_full_range
      assign in_range = 1'b1;
    end else begin : g_limited_range
      assign in_range = (int'(flag_b) < NUM_FLAGS);
    end
  endgenerate

  always_comb begin
    upd_o.wt   = vld_i && in_range && (op_b == OP_WEIGHT);
    upd_o.ps   = vld_i && in_range && (op_b == OP_PERSIST);
    upd_o.flag = flag_b;
    upd_o.val  = val_b;
  end

endmodule

// File: rtl/cos_update_out.sv
module cos_update_out
  import cos_pkg::*;
#(
  parameter int NUM_FLAGS = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  upd_s       upd_i,
  input  logic       fin_i,
  output logic       wt_we_o,
  output logic [7:0] wt_flag_o,
  output logic [7:0] wt_val_o,
  output logic       ps_we_o,
  output logic [7:0] ps_flag_o,
  output logic [7:0] ps_val_o,
  output logic       done_o
);

  logic       wt_we_q, ps_we_q, pend_q, done_q;
  logic [7:0] wt_flag_q, wt_val_q, ps_flag_q, ps_val_q;
  logic       wt_load, ps_load;

  // clock enables for the data registers
  assign wt_load = upd_i.wt;
  assign ps_load = upd_i.ps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wt_we_q <= 1'b0;
      ps_we_q <= 1'b0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      wt_we_q <= upd_i.wt;
      ps_we_q <= upd_i.ps;
      pend_q  <= fin_i;
      done_q  <= pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wt_flag_q <= '0;
      wt_val_q  <= '0;
    end else if (wt_load) begin
      wt_flag_q <= upd_i.flag;
      wt_val_q  <= upd_i.val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_flag_q <= '0;
      ps_val_q  <= '0;
    end else if (ps_load) begin
      ps_flag_q <= upd_i.flag;
      ps_val_q  <= upd_i.val;
    end
  end

  assign wt_we_o   = wt_we_q;
  assign wt_flag_o = wt_flag_q;
  assign wt_val_o  = wt_val_q;
  assign ps_we_o   = ps_we_q;
  assign ps_flag_o = ps_flag_q;
  assign ps_val_o  = ps_val_q;
  assign done_o    = done_q;

  assert_single_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wt_we_o && ps_we_o));

  assert_wt_flag_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wt_we_o |-> (int'(wt_flag_o) < NUM_FLAGS));

  assert_ps_flag_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ps_we_o |-> (int'(ps_flag_o) < NUM_FLAGS));

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!wt_we_o && !ps_we_o));

endmodule

// File: rtl/cfg_override_scanner.sv
module cfg_override_scanner
  import cos_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_FLAGS = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W:0]   len_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [31:0]       rd_data_i,
  output logic              wt_we_o,
  output logic [7:0]        wt_flag_o,
  output logic [7:0]        wt_val_o,
  output logic              ps_we_o,
  output logic [7:0]        ps_flag_o,
  output logic [7:0]        ps_val_o,
  output logic              done_o
);

  logic seq_rd, seq_last, seq_empty;
  logic vld_q, lst_q, emp_q;
  upd_s upd;

  cos_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .base_i    (base_i),
    .len_i     (len_i),
    .rd_en_o   (seq_rd),
    .rd_addr_o (rd_addr_o),
    .last_o    (seq_last),
    .empty_o   (seq_empty)
  );

  assign rd_en_o = seq_rd;

  // read latency alignment: data returns one cycle after the request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      lst_q <= 1'b0;
      emp_q <= 1'b0;
    end else begin
      vld_q <= seq_rd;
      lst_q <= seq_last;
      emp_q <= seq_empty;
    end
  end

  cos_word_decode #(.NUM_FLAGS(NUM_FLAGS)) u_dec (
    .vld_i  (vld_q),
    .word_i (rd_data_i),
    .upd_o  (upd)
  );

  cos_update_out #(.NUM_FLAGS(NUM_FLAGS)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_i     (upd),
    .fin_i     (lst_q || emp_q),
    .wt_we_o   (wt_we_o),
    .wt_flag_o (wt_flag_o),
    .wt_val_o  (wt_val_o),
    .ps_we_o   (ps_we_o),
    .ps_flag_o (ps_flag_o),
    .ps_val_o  (ps_val_o),
    .done_o    (done_o)
  );

  assert_strobe_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_we_o || ps_we_o) |-> $past(vld_q));

endmodule

// File: tb/cfg_override_scanner_tb.sv
`timescale 1ns/1ps
module cfg_override_scanner_tb;

  localparam int ADDR_W    = 8;
  localparam int NUM_FLAGS = 48;

  typedef struct {
    bit       is_wt;
    bit [7:0] flag;
    bit [7:0] val;
  } exp_t;

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic [ADDR_W-1:0] base_i;
  logic [ADDR_W:0]   len_i;
  logic              rd_en_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic [31:0]       rd_data_i;
  logic              wt_we_o, ps_we_o, done_o;
  logic [7:0]        wt_flag_o, wt_val_o, ps_flag_o, ps_val_o;

  logic [31:0] mem [256];
  exp_t        exp_q[$];
  int          n_checks;
  int          n_err;
  int          rd_cnt;
  int          done_cnt;
  logic [7:0]  exp_addr;
  bit          prev_done;

  cfg_override_scanner #(.ADDR_W(ADDR_W), .NUM_FLAGS(NUM_FLAGS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .len_i(len_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .wt_we_o(wt_we_o), .wt_flag_o(wt_flag_o), .wt_val_o(wt_val_o),
    .ps_we_o(ps_we_o), .ps_flag_o(ps_flag_o), .ps_val_o(ps_val_o),
    .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // memory model with one-cycle read latency
  always @(posedge clk) begin
    if (rd_en_o) rd_data_i <= mem[rd_addr_o];
  end

  function automatic void chk(input bit ok, input string tag, input string what,
                              input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endfunction

  // expected decode, taken straight from R1..R5
  function automatic void expect_word(input logic [31:0] w);
    exp_t e;
    if (w[23:16] < NUM_FLAGS && (w[7:0] == 8'hA2 || w[7:0] == 8'h8E)) begin
      e.is_wt = (w[7:0] == 8'hA2);
      e.flag  = w[23:16];
      e.val   = w[15:8];
      exp_q.push_back(e);
    end
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n) begin
      if (rd_en_o) begin
        chk(rd_addr_o == exp_addr, "R6", "read address order", rd_addr_o, exp_addr);
        exp_addr = exp_addr + 8'd1;
        rd_cnt++;
      end
      if (wt_we_o && ps_we_o) chk(1'b0, "R7", "both ports strobed", 1, 0);
      if (wt_we_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected weight update", wt_flag_o, 0);
        else begin
          e = exp_q.pop_front();
          chk(e.is_wt && e.flag == wt_flag_o && e.val == wt_val_o, "R1",
              "weight update {kind,flag,val}", {1'b1, wt_flag_o, wt_val_o}, {e.is_wt, e.flag, e.val});
        end
      end
      if (ps_we_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected persistence update", ps_flag_o, 0);
        else begin
          e = exp_q.pop_front();
          chk(!e.is_wt && e.flag == ps_flag_o && e.val == ps_val_o, "R2",
              "persistence update {kind,flag,val}", {1'b0, ps_flag_o, ps_val_o}, {e.is_wt, e.flag, e.val});
        end
      end
      if (done_o) begin
        done_cnt++;
        if (prev_done) chk(1'b0, "R8", "done wider than one cycle", 2, 1);
      end
      prev_done = done_o;
    end
  end

  task automatic scan(input int base, input int len, input bit repulse, input string tag);
    int waited;
    for (int i = 0; i < len; i++) expect_word(mem[(base + i) % 256]);
    exp_addr = 8'(base);
    rd_cnt   = 0;
    done_cnt = 0;
    @(negedge clk);
    start_i = 1'b1;
    base_i  = 8'(base);
    len_i   = 9'(len);
    @(negedge clk);
    start_i = 1'b0;
    if (repulse) begin
      // R9: a second start mid-scan with other settings
      repeat (2) @(negedge clk);
      start_i = 1'b1;
      base_i  = 8'(base + 40);
      len_i   = 9'd3;
      @(negedge clk);
      start_i = 1'b0;
    end
    waited = 0;
    while (done_cnt == 0 && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    repeat (6) @(negedge clk);
    chk(done_cnt == 1, repulse ? "R9" : "R8", {tag, " done pulse count"}, done_cnt, 1);
    chk(rd_cnt == len, repulse ? "R9" : "R6", {tag, " read count"}, rd_cnt, len);
    chk(exp_q.size() == 0, tag, "updates missing", exp_q.size(), 0);
    exp_q.delete();
  endtask

  // global watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R8 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    n_checks = 0; n_err = 0; rd_cnt = 0; done_cnt = 0; prev_done = 0; exp_addr = '0;
    start_i = 1'b0; base_i = '0; len_i = '0; rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    // R10: outputs quiet during reset
    chk(!rd_en_o && !wt_we_o && !ps_we_o && !done_o, "R10", "outputs in reset",
        {rd_en_o, wt_we_o, ps_we_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_en_o && !wt_we_o && !ps_we_o && !done_o, "R10", "outputs after reset",
        {rd_en_o, wt_we_o, ps_we_o, done_o}, 0);

    // mixed section: R1 R2 R3 R4 R5 R6
    mem[16] = 32'hAA0533A2;   // weight flag 5 = 0x33 (R1)
    mem[17] = 32'hBB07118E;   // persistence flag 7 = 0x11 (R2)
    mem[18] = 32'h000544A2;   // top byte 0x00 still decodes (R3)
    mem[19] = 32'hFF09208E;   // top byte 0xFF still decodes (R3)
    mem[20] = 32'h00000000;   // zero word skipped (R4)
    mem[21] = 32'hC1AA1222;   // unknown word skipped (R4)
    mem[22] = 32'hAA3001A2;   // flag 48, out of range (R5)
    mem[23] = 32'hBB2F028E;   // flag 47, last legal (R5)
    mem[24] = 32'h12345678;   // unknown (R4)
    mem[25] = 32'hAA0555A2;   // flag 5 again, comes last (R6)
    scan(16, 10, 1'b0, "R1");

    // zero-filled area: R4
    scan(40, 8, 1'b0, "R4");

    // empty section: R8
    scan(60, 0, 1'b0, "R8");

    // dense back-to-back pattern: R7, R5
    for (int i = 0; i < 20; i++) begin
      case (i % 3)
        0:       mem[100 + i] = {8'hAA, 8'(i), 8'(i * 7), 8'hA2};
        1:       mem[100 + i] = {8'hBB, 8'(i + 30), 8'(i * 5), 8'h8E};
        default: mem[100 + i] = 32'(i) * 32'h9E3779B9;
      endcase
    end
    scan(100, 20, 1'b0, "R7");

    // restart during a scan: R9
    for (int i = 0; i < 12; i++)
      mem[150 + i] = (i % 2 == 0) ? {8'h00, 8'(i), 8'(i + 1), 8'hA2}
                                  : {8'h00, 8'(i), 8'(i + 2), 8'h8E};
    for (int i = 0; i < 8; i++) mem[190 + i] = {8'h00, 8'd3, 8'hEE, 8'hA2};
    scan(150, 12, 1'b1, "R9");

    // section that wraps past the top address: R6
    mem[254] = 32'h000A01A2;
    mem[255] = 32'h000B028E;
    mem[0]   = 32'h000C03A2;
    scan(254, 3, 1'b0, "R6");

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule